// File: doc/BRIEF.md
# Serial DAC Input Register Interface

This block is the receiving side of a three-wire serial link that loads a 10-bit digital-to-analog converter. A host drives a chip-select line low, clocks serial data in most significant bit first on the rising edges of a serial clock, and raises chip-select to commit the word. The data word is taken from fixed bit positions of a 16-bit shift register. Hosts may therefore send either a 12-bit frame or a 16-bit frame. A 12-bit frame is ten data bits followed by two padding bits. A 16-bit frame is four leading padding bits, then the ten data bits, then the two trailing padding bits.

A cascade output repeats the shift register's top bit, updated on falling serial-clock edges. This lets several devices share one chip-select while the data passes from one to the next. The link runs in clock polarity 0, clock phase 0. All three serial lines are sampled by a system clock that runs at least four times faster than the serial clock. Each line passes through a multi-stage synchronizer, and edge detectors then turn the transitions into single-cycle events. The parallel result is a 10-bit holding register and a one-cycle load strobe. The analog conversion is not part of this block.

Top module: `sdac_serial_rx`

## Requirements
- R1: A synchronized rising edge of the serial clock shifts one bit into the 16-bit shift register, most significant bit first, but only while the synchronized chip-select is low (active-low chip-select).
- R2: While chip-select is high, serial clock edges leave the shift register unchanged. A later chip-select low-then-high pulse with no clocks must re-latch the earlier value.
- R3: On a synchronized rising edge of chip-select, the holding register takes shift register bits [11:2]. Bit 11 becomes `dac_value[9]`. At no other time does the holding register change.
- R4: After a 12-bit frame (10 data bits MSB first, then 2 ignored bits), `dac_value` equals the 10 data bits.
- R5: After a 16-bit frame (4 ignored bits, then 10 data bits MSB first, then 2 ignored bits), `dac_value` equals the 10 data bits, whatever the padding holds.
- R6: `load_pulse` is high for exactly one system clock per chip-select rise. It goes high on the third rising system clock edge after the chip-select pin rises, and `dac_value` updates on that same edge.
- R7: `sdo` takes the shift register's bit 15 on each synchronized falling edge of the serial clock and holds its value otherwise. With chip-select held low, the first bit of a stream appears on `sdo` after the 16th falling edge.
- R8: While `rst_n` is low, `dac_value` is 0, `load_pulse` is 0 and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_in | input | 1 | Chip-select from the host, active low, asynchronous |
| sclk_in | input | 1 | Serial clock from the host, asynchronous |
| sdi_in | input | 1 | Serial data from the host, asynchronous |
| sdo | output | 1 | Cascade data output (shift register MSB) |
| dac_value | output | 10 | Holding register contents |
| load_pulse | output | 1 | One-cycle strobe when the holding register loads |

## Verification
The hardest state to reach from the ports is a stream held under chip-select for longer than 16 clocks. Only in that state does the cascade output carry bits that entered the shift register 16 clocks earlier. The bench sends one 32-bit burst made of two distinct 16-bit words and records `sdo` after every falling edge. It then checks that the second half of the record reproduces the first word. The frozen-register case is reached by toggling the serial clock with data high while chip-select is high. A bare chip-select pulse then exposes the shift register contents through `dac_value`.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_kind_e;

   localparam int LINE_CS   = 0;
   localparam int LINE_SCLK = 1;
   localparam int LINE_SDI  = 2;
   localparam int LINE_CNT  = 3;

   localparam logic [LINE_CNT-1:0] LINE_IDLE = 3'b001;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sdac_sync: STAGES must be at least 2");
      end

      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= RST_VAL;
               else        stage_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sdac_edge.sv
module sdac_edge
   import sdac_pkg::*;
#(
   parameter edge_kind_e KIND    = EDGE_RISE,
   parameter logic       RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic evt_o
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= level_i;
   end

   generate
      if (KIND == EDGE_RISE) begin : g_rise
         assign evt_o = level_i & ~prev_q;
      end else begin : g_fall
         assign evt_o = ~level_i & prev_q;
      end
   endgenerate

   // R6 / R7: an event of either kind lasts a single system cycle
   assert_evt_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |=> !evt_o);

endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
   parameter int SHIFT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en_i,
   input  logic               bit_i,
   input  logic               out_evt_i,
   output logic [SHIFT_W-1:0] word_o,
   output logic               sdo_o
);

   logic [SHIFT_W-1:0] word_q;
   logic               sdo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          word_q <= '0;
      else if (shift_en_i) word_q <= {word_q[SHIFT_W-2:0], bit_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sdo_q <= 1'b0;
      else if (out_evt_i) sdo_q <= word_q[SHIFT_W-1];
   end

   assign word_o = word_q;
   assign sdo_o  = sdo_q;

   // R1 / R2: without a qualified shift the register stays put
   assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en_i |=> $stable(word_q));

   // R7: the cascade output only moves on a falling serial edge
   assert_sdo_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_evt_i |=> $stable(sdo_q));

endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
   parameter int SHIFT_W  = 16,
   parameter int DATA_W   = 10,
   parameter int DATA_LSB = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               latch_i,
   input  logic [SHIFT_W-1:0] word_i,
   output logic [DATA_W-1:0]  value_o,
   output logic               load_o
);

   localparam int DATA_MSB = DATA_LSB + DATA_W - 1;

   logic [DATA_W-1:0] value_q;
   logic              load_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q <= '0;
         load_q  <= 1'b0;
      end else begin
         load_q <= latch_i;
         if (latch_i) value_q <= word_i[DATA_MSB:DATA_LSB];
      end
   end

   assign value_o = value_q;
   assign load_o  = load_q;

   // R3: the holding register moves only together with the strobe
   assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !load_q |-> (value_q == $past(value_q)));

   // R6: the strobe never spans two cycles
   assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_q |=> !load_q);

   // R8: reset values
   always_comb begin
      if (!rst_n) begin
         assert_reset_clear_R8: assert ((value_q == '0) && !load_q);
      end
   end

endmodule

// File: rtl/sdac_serial_rx.sv
module sdac_serial_rx
   import sdac_pkg::*;
#(
   parameter int SHIFT_W     = 16,
   parameter int DATA_W      = 10,
   parameter int DATA_LSB    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_in,
   input  logic              sclk_in,
   input  logic              sdi_in,
   output logic              sdo,
   output logic [DATA_W-1:0] dac_value,
   output logic              load_pulse
);

   localparam int FIELD_TOP = DATA_LSB + DATA_W;

   generate
      if (FIELD_TOP > SHIFT_W) begin : g_bad_field
         $error("sdac_serial_rx: data field exceeds shift register");
      end
      if (SHIFT_W < 2) begin : g_bad_shift
         $error("sdac_serial_rx: SHIFT_W must be at least 2");
      end
   endgenerate

   logic [LINE_CNT-1:0] lines_raw;
   logic [LINE_CNT-1:0] lines_sync;
   logic                cs_rise;
   logic                sclk_rise;
   logic                sclk_fall;
   logic                shift_en;
   logic [SHIFT_W-1:0]  shift_word;

   assign lines_raw[LINE_CS]   = cs_n_in;
   assign lines_raw[LINE_SCLK] = sclk_in;
   assign lines_raw[LINE_SDI]  = sdi_in;

   sdac_sync #(
      .WIDTH   (LINE_CNT),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (LINE_IDLE)
   ) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (lines_raw),
      .sync_o  (lines_sync)
   );

   sdac_edge #(.KIND(EDGE_RISE), .RST_VAL(1'b1)) cs_rise_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (lines_sync[LINE_CS]),
      .evt_o   (cs_rise)
   );

   sdac_edge #(.KIND(EDGE_RISE), .RST_VAL(1'b0)) sclk_rise_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (lines_sync[LINE_SCLK]),
      .evt_o   (sclk_rise)
   );

   sdac_edge #(.KIND(EDGE_FALL), .RST_VAL(1'b0)) sclk_fall_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (lines_sync[LINE_SCLK]),
      .evt_o   (sclk_fall)
   );

   assign shift_en = sclk_rise & ~lines_sync[LINE_CS];

   sdac_shift #(.SHIFT_W(SHIFT_W)) shift_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_en_i (shift_en),
      .bit_i      (lines_sync[LINE_SDI]),
      .out_evt_i  (sclk_fall),
      .word_o     (shift_word),
      .sdo_o      (sdo)
   );

   sdac_hold #(
      .SHIFT_W  (SHIFT_W),
      .DATA_W   (DATA_W),
      .DATA_LSB (DATA_LSB)
   ) hold_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .latch_i (cs_rise),
      .word_i  (shift_word),
      .value_o (dac_value),
      .load_o  (load_pulse)
   );

   // R1: rising and falling serial events never coincide
   assert_edge_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(sclk_rise && sclk_fall));

   // R6: a strobe follows a chip-select rise one cycle later
   assert_strobe_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> load_pulse);

endmodule

// File: tb/sdac_serial_rx_tb.sv
module sdac_serial_rx_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       sdi = 1'b0;
   logic       sdo;
   logic [9:0] dac_value;
   logic       load_pulse;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   always #10 clk = ~clk;

   sdac_serial_rx dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n_in    (cs_n),
      .sclk_in    (sclk),
      .sdi_in     (sdi),
      .sdo        (sdo),
      .dac_value  (dac_value),
      .load_pulse (load_pulse)
   );

   // behavioural reference: pin history, event decode, integer state
   int cs_h[$];
   int ck_h[$];
   int di_h[$];
   int m_sh, m_dac, m_pulse, m_sdo;

   always @(posedge clk) begin
      if (!rst_n) begin
         cs_h = {1, 1, 1, 1};
         ck_h = {0, 0, 0, 0};
         di_h = {0, 0, 0, 0};
         m_sh = 0; m_dac = 0; m_pulse = 0; m_sdo = 0;
      end else begin
         int old;
         cs_h.push_front(int'(cs_n));
         ck_h.push_front(int'(sclk));
         di_h.push_front(int'(sdi));
         old = m_sh;
         m_pulse = 0;
         if (ck_h[2] == 1 && ck_h[3] == 0 && cs_h[2] == 0)
            m_sh = ((old << 1) | di_h[2]) & 32'hFFFF;
         if (ck_h[2] == 0 && ck_h[3] == 1)
            m_sdo = (old >> 15) & 1;
         if (cs_h[2] == 1 && cs_h[3] == 0) begin
            m_dac = (old >> 2) & 32'h3FF;
            m_pulse = 1;
         end
         while (cs_h.size() > 4) begin
            void'(cs_h.pop_back());
            void'(ck_h.pop_back());
            void'(di_h.pop_back());
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         chk("R3 dac_value vs model", int'(dac_value), m_dac);
         chk("R6 load_pulse vs model", int'(load_pulse), m_pulse);
         chk("R7 sdo vs model", int'(sdo), m_sdo);
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   int caps[0:32];

   task automatic frame(input logic [31:0] bits, input int n);
      int pv[1:4];
      cs_n = 1'b0;
      step(4);
      for (int i = n - 1; i >= 0; i--) begin
         sdi = bits[i];
         step(3);
         if (i != n - 1) caps[n - 1 - i] = int'(sdo);
         sclk = 1'b1;
         step(3);
         sclk = 1'b0;
      end
      step(3);
      caps[n] = int'(sdo);
      cs_n = 1'b1;
      for (int k = 1; k <= 4; k++) begin
         step(1);
         pv[k] = int'(load_pulse);
      end
      chk("R6 strobe edge1", pv[1], 0);
      chk("R6 strobe edge2", pv[2], 0);
      chk("R6 strobe edge3", pv[3], 1);
      chk("R6 strobe edge4", pv[4], 0);
      step(4);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [15:0] wa;
      logic [15:0] wb;
      step(3);
      // R8: reset state
      chk("R8 reset dac_value", int'(dac_value), 0);
      chk("R8 reset load_pulse", int'(load_pulse), 0);
      chk("R8 reset sdo", int'(sdo), 0);
      rst_n = 1'b1;
      step(4);

      // R4: 12-bit frame, padding high
      frame({20'd0, 10'h2A5, 2'b11}, 12);
      chk("R4 12-bit frame", int'(dac_value), 'h2A5);

      // R5: 16-bit frame with nonzero leading padding
      frame({16'd0, 4'hF, 10'h15A, 2'b01}, 16);
      chk("R5 16-bit frame", int'(dac_value), 'h15A);

      // R5: full scale with zero padding
      frame({16'd0, 4'h0, 10'h3FF, 2'b00}, 16);
      chk("R5 full scale", int'(dac_value), 'h3FF);

      // R4: zero data after a full-scale frame, R1 MSB-first ordering
      frame({20'd0, 10'h000, 2'b10}, 12);
      chk("R4 zero after full scale", int'(dac_value), 'h000);
      frame({20'd0, 10'h201, 2'b00}, 12);
      chk("R1 bit order", int'(dac_value), 'h201);

      // R2: clock activity with chip-select high is ignored
      sdi = 1'b1;
      for (int t = 0; t < 8; t++) begin
         sclk = 1'b1; step(3);
         sclk = 1'b0; step(3);
      end
      chk("R2 no latch while high", int'(dac_value), 'h201);
      frame(32'd0, 0);
      chk("R2 register frozen", int'(dac_value), 'h201);

      // R7: cascade output repeats a word after 16 falling edges
      wa = 16'hC3A5;
      wb = 16'h5E1C;
      frame({wa, wb}, 32);
      for (int i = 0; i < 16; i++)
         chk($sformatf("R7 cascade bit %0d", i), caps[16 + i], int'(wa[15 - i]));
      chk("R7 first bit of second word", caps[32], int'(wb[15]));
      chk("R3 long burst keeps last bits", int'(dac_value), int'(wb[11:2]));

      step(10);
      finish_run();
   end

endmodule